// File: doc/BRIEF.md
# Dithered Bit-Period Generator

This block sets the length of every bit on one serial bus channel. It works from a 64 MHz tick. Each bit lasts a programmable floor of 320 ticks plus twice an 8-bit base select. On top of that it adds a pseudo-random extra count, so the energy radiated by the bus is spread across many frequencies rather than concentrated at one bit rate. The floor alone covers about 77.1 kbps to 200 kbps, and the shortest bit is 5 µs.

A 24-bit maximal-length LFSR supplies 7 random bits for each bit. A 3-bit deviation select caps this random value by masking it, and the capped value is added to the floor. The bus sequencer asks for a bit with `next_req`. The generator then latches the period, reports it on `period_out`, and raises `bit_tick` in the last tick of the bit. If `next_req` is still high at that point, the next bit follows with no gap. Each channel uses its own instance, so each channel keeps its own settings and its own random sequence.

Top module: `dither_bit_timer`

## Requirements
- R1: After reset, `period_out` is 0, `bit_tick` is low, and no bit is in progress.
- R2: The period of a bit is 320 + 2·`base_sel` + extra, in 64 MHz ticks. It is latched in the cycle that accepts the request, and `period_out` shows it from the next cycle on.
- R3: The LFSR is 24 bits wide and loads seed 24'h1D2C3B at reset. It shifts left, and its new bit 0 is the XOR of state bits 23, 22, 21 and 16. It advances exactly once for each accepted bit, and the random value is the 7 low bits of the advanced state.
- R4: When `dev_sel` is 0, the extra count is 0, so every bit has the same period.
- R5: When `dev_sel` is 1 to 6, the extra count is the random value ANDed with 2^(`dev_sel`+1)−1.
- R6: When `dev_sel` is 7, the extra count is twice the random value (0 to 254).
- R7: `bit_tick` is high for exactly one cycle per bit. That cycle is the P-th cycle after the accepting edge, where P is the latched period.
- R8: If `next_req` is high during the `bit_tick` cycle, the next bit is accepted at that edge, and successive ticks are exactly one period apart.
- R9: Changes to `base_sel` or `dev_sel` during a bit do not change that bit's period or tick timing.
- R10: While `enable` is low, any bit in progress is aborted, no `bit_tick` occurs, `next_req` is ignored, and the LFSR does not advance.
- R11: A `next_req` pulse during a bit, outside its `bit_tick` cycle, is ignored: it neither shortens the bit nor advances the LFSR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 64 MHz tick clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Channel enable; low aborts and idles |
| base_sel | input | 8 | Base period select (adds 2 ticks per step) |
| dev_sel | input | 3 | Maximum-deviation select, 0 disables spreading |
| next_req | input | 1 | Request for the next bit |
| period_out | output | 11 | Period of the current bit in ticks |
| bit_tick | output | 1 | One-cycle pulse in the last tick of each bit |

## Verification
The embedded assertions check the following on every cycle:
- the countdown decrements by exactly one;
- the latched period is held steady while a bit runs;
- the period never drops below the floor;
- the LFSR never reaches the all-zero state;
- no tick occurs while disabled;
- with deviation 0, the period equals the arithmetic floor.

Only the bench's scenarios show the following:
- the exact random sequence and the masking and scaling for each deviation setting, because its model steps its own LFSR and compares every latched period and every tick interval;
- that aborted or ignored requests leave the sequence untouched.

// File: rtl/dither_pkg.sv
package dither_pkg;
   // Floor of every bit period, in clock ticks.
   localparam int unsigned FLOOR_TICKS = 320;
   // Default LFSR seed and feedback tap mask (bits 23, 22, 21, 16).
   localparam logic [23:0] LFSR_SEED_DEF = 24'h1D2C3B;
   localparam logic [23:0] LFSR_TAPS_DEF = 24'hE10000;

   // Smallest unsigned width able to hold value v.
   function automatic int unsigned width_for(input int unsigned v);
      int unsigned w;
      w = 1;
      while ((64'd1 << w) <= 64'(v)) w++;
      return w;
   endfunction
endpackage

// File: rtl/dither_lfsr.sv
module dither_lfsr #(
   parameter int unsigned       W     = 24,
   parameter int unsigned       OUT_W = 7,
   parameter logic [W-1:0]      SEED  = dither_pkg::LFSR_SEED_DEF,
   parameter logic [W-1:0]      TAPS  = dither_pkg::LFSR_TAPS_DEF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             advance,
   output logic [OUT_W-1:0] rnd_next
);
   if (OUT_W > W) $error("dither_lfsr: OUT_W must not exceed W");
   if (SEED == '0) $error("dither_lfsr: seed must be non-zero");

   logic [W-1:0] state_q;
   logic [W-1:0] state_nx;
   logic         feedback;

   always_comb begin
      feedback = ^(state_q & TAPS);
      state_nx = {state_q[W-2:0], feedback};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       state_q <= SEED;
      else if (advance) state_q <= state_nx;
   end

   assign rnd_next = state_nx[OUT_W-1:0];

   a_r3_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      state_q != '0);
   a_r3_lfsr_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !advance |=> $stable(state_q));
endmodule

// File: rtl/dither_dev_limit.sv
module dither_dev_limit #(
   parameter int unsigned RND_W     = 7,
   parameter int unsigned DEV_W     = 3,
   parameter bit          SCALE_TOP = 1'b1,
   localparam int unsigned EXTRA_W  = RND_W + 1
) (
   input  logic [RND_W-1:0]   rnd,
   input  logic [DEV_W-1:0]   dev_sel,
   output logic [EXTRA_W-1:0] extra
);
   localparam logic [DEV_W-1:0] DEV_TOP = {DEV_W{1'b1}};

   logic [EXTRA_W-1:0] cap_mask;
   logic [EXTRA_W-1:0] masked;

   // Cap of 2^(dev+1)-1: ones in bit positions 0..dev.
   always_comb begin
      cap_mask = '0;
      for (int i = 0; i < int'(EXTRA_W); i++)
         cap_mask[i] = (i <= int'(dev_sel));
      masked = {1'b0, rnd} & cap_mask;
   end

   if (SCALE_TOP) begin : g_scaled_top
      always_comb begin
         if (dev_sel == '0)          extra = '0;
         else if (dev_sel == DEV_TOP) extra = {rnd, 1'b0};
         else                        extra = masked;
      end
   end else begin : g_plain_top
      always_comb begin
         if (dev_sel == '0) extra = '0;
         else               extra = masked;
      end
   end

   always_comb begin
      a_r5_within_cap: assert (dev_sel == '0 || extra <= cap_mask);
   end
endmodule

// File: rtl/dither_period_ctr.sv
module dither_period_ctr #(
   parameter int unsigned PER_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             req,
   input  logic [PER_W-1:0] new_period,
   output logic             accept,
   output logic             tick,
   output logic             busy,
   output logic [PER_W-1:0] period_q
);
   logic [PER_W-1:0] cnt_q;

   assign tick   = enable && busy && (cnt_q == '0);
   assign accept = enable && req && (!busy || tick);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         cnt_q    <= '0;
         period_q <= '0;
      end else if (!enable) begin
         busy  <= 1'b0;
         cnt_q <= '0;
      end else if (accept) begin
         busy     <= 1'b1;
         cnt_q    <= new_period - PER_W'(1);
         period_q <= new_period;
      end else if (tick) begin
         busy <= 1'b0;
      end else if (busy) begin
         cnt_q <= cnt_q - PER_W'(1);
      end
   end

   a_r7_count_down: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && busy && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - PER_W'(1)));
   a_r9_period_held: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !tick) |=> $stable(period_q));
   a_r7_tick_ends_bit: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !req) |=> !busy);
   a_r10_disable_idles: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> !busy);
endmodule

// File: rtl/dither_bit_timer.sv
module dither_bit_timer #(
   parameter int unsigned BASE_W    = 8,
   parameter int unsigned DEV_W     = 3,
   parameter int unsigned RND_W     = 7,
   parameter int unsigned LFSR_W    = 24,
   parameter bit          SCALE_TOP = 1'b1,
   localparam int unsigned EXTRA_W  = RND_W + 1,
   localparam int unsigned MAX_PER  = dither_pkg::FLOOR_TICKS
                                      + 2 * ((1 << BASE_W) - 1)
                                      + ((1 << EXTRA_W) - 1),
   localparam int unsigned PER_W    = dither_pkg::width_for(MAX_PER)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic [BASE_W-1:0] base_sel,
   input  logic [DEV_W-1:0]  dev_sel,
   input  logic              next_req,
   output logic [PER_W-1:0]  period_out,
   output logic              bit_tick
);
   if (RND_W + 1 < (1 << DEV_W) - 1) $error("dither_bit_timer: random width too small for deviation range");
   if (RND_W >= LFSR_W) $error("dither_bit_timer: random width must be below LFSR width");
   if (BASE_W < 1) $error("dither_bit_timer: base select needs at least one bit");

   localparam logic [PER_W-1:0] FLOOR = PER_W'(dither_pkg::FLOOR_TICKS);

   logic [RND_W-1:0]   rnd;
   logic [EXTRA_W-1:0] extra;
   logic [PER_W-1:0]   new_period;
   logic               accept;
   logic               busy;

   dither_lfsr #(
      .W    (LFSR_W),
      .OUT_W(RND_W),
      .SEED (LFSR_W'(dither_pkg::LFSR_SEED_DEF)),
      .TAPS (LFSR_W'(dither_pkg::LFSR_TAPS_DEF))
   ) u_lfsr (
      .clk     (clk),
      .rst_n   (rst_n),
      .advance (accept),
      .rnd_next(rnd)
   );

   dither_dev_limit #(
      .RND_W    (RND_W),
      .DEV_W    (DEV_W),
      .SCALE_TOP(SCALE_TOP)
   ) u_limit (
      .rnd    (rnd),
      .dev_sel(dev_sel),
      .extra  (extra)
   );

   always_comb begin
      new_period = FLOOR + PER_W'({base_sel, 1'b0}) + PER_W'(extra);
   end

   dither_period_ctr #(
      .PER_W(PER_W)
   ) u_ctr (
      .clk       (clk),
      .rst_n     (rst_n),
      .enable    (enable),
      .req       (next_req),
      .new_period(new_period),
      .accept    (accept),
      .tick      (bit_tick),
      .busy      (busy),
      .period_q  (period_out)
   );

   a_r2_period_floor: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (period_out >= FLOOR));
   a_r4_no_spread: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && dev_sel == '0) |=>
         (period_out == FLOOR + PER_W'({$past(base_sel), 1'b0})));
   a_r10_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |-> !bit_tick);
   a_r1_idle_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !bit_tick);
endmodule

// File: tb/dither_bit_timer_test.sv
module dither_bit_timer_test;
   localparam int CLK_PERIOD = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enable = 1'b0;
   logic [7:0]  base_sel = '0;
   logic [2:0]  dev_sel = '0;
   logic        next_req = 1'b0;
   logic [10:0] period_out;
   logic        bit_tick;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;
   logic [23:0] model = 24'h1D2C3B;

   always #(CLK_PERIOD/2) clk = ~clk;

   dither_bit_timer uut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .base_sel(base_sel),
      .dev_sel(dev_sel), .next_req(next_req), .period_out(period_out),
      .bit_tick(bit_tick)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Expected period of the next accepted bit; steps the model LFSR (R3).
   function automatic int next_expected(input int b, input int d);
      logic fb;
      int   r, ex;
      fb = model[23] ^ model[22] ^ model[21] ^ model[16];
      model = {model[22:0], fb};
      r = int'(model[6:0]);
      if (d == 0)      ex = 0;                           // R4
      else if (d == 7) ex = 2 * r;                       // R6
      else             ex = r & ((1 << (d + 1)) - 1);    // R5
      return 320 + 2 * b + ex;                           // R2
   endfunction

   // Count negedges from the one after acceptance until bit_tick (R7).
   task automatic measure(input int exp, input string req, input bit change_mid, input bit poke_mid);
      int k;
      k = 1;
      check(period_out == 11'(exp), req, int'(period_out), exp);
      while (!bit_tick && k < 2000) begin
         if (change_mid && k == 5) begin base_sel = ~base_sel; dev_sel = ~dev_sel; end
         if (poke_mid && k == 7) next_req = 1'b1;
         if (poke_mid && k == 8) next_req = 1'b0;
         if (change_mid || poke_mid) check(period_out == 11'(exp), req, int'(period_out), exp);
         @(negedge clk);
         k++;
      end
      check(k == exp, req, k, exp);
   endtask

   task automatic one_bit(input int b, input int d, input string req, input bit change_mid, input bit poke_mid);
      int exp;
      base_sel = 8'(b); dev_sel = 3'(d);
      exp = next_expected(b, d);
      next_req = 1'b1;
      @(negedge clk);
      next_req = 1'b0;
      measure(exp, req, change_mid, poke_mid);
      @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      int exp;
      int ticks;
      @(negedge clk);
      @(negedge clk);
      // R1: reset state
      check(period_out == 0, "R1", int'(period_out), 0);
      check(bit_tick == 0, "R1", int'(bit_tick), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(period_out == 0 && !bit_tick, "R1", int'(period_out), 0);
      enable = 1'b1;
      @(negedge clk);

      // R2 R4: constant period without spreading
      one_bit(0, 0, "R4", 0, 0);
      one_bit(0, 0, "R4", 0, 0);
      one_bit(255, 0, "R2", 0, 0);
      // R3 R5 R6: sweep of deviation settings over several bases
      for (int d = 1; d < 8; d++) begin
         one_bit(0, d, (d == 7) ? "R6" : "R5", 0, 0);
         one_bit(137, d, (d == 7) ? "R6" : "R5", 0, 0);
         one_bit(255, d, "R3", 0, 0);
      end

      // R9: settings changed during a bit
      one_bit(40, 6, "R9", 1, 0);
      // R11: a request pulse mid-bit is ignored
      one_bit(10, 5, "R11", 0, 1);
      one_bit(10, 5, "R11", 0, 0);

      // R8: back-to-back bits with next_req held high
      base_sel = 8'd20; dev_sel = 3'd4;
      next_req = 1'b1;
      for (int n = 0; n < 4; n++) begin
         exp = next_expected(20, 4);
         @(negedge clk);
         measure(exp, "R8", 0, 0);
      end
      next_req = 1'b0;
      @(negedge clk);
      @(negedge clk);
      check(bit_tick == 0, "R8", int'(bit_tick), 0);

      // R10: abort mid-bit, requests ignored while off, no LFSR advance
      base_sel = 8'd3; dev_sel = 3'd7;
      exp = next_expected(3, 7);
      next_req = 1'b1;
      @(negedge clk);
      next_req = 1'b0;
      check(period_out == 11'(exp), "R10", int'(period_out), exp);
      repeat (10) @(negedge clk);
      enable = 1'b0;
      next_req = 1'b1;
      ticks = 0;
      for (int c = 0; c < 1300; c++) begin
         if (bit_tick) ticks++;
         @(negedge clk);
      end
      check(ticks == 0, "R10", ticks, 0);
      next_req = 1'b0;
      enable = 1'b1;
      @(negedge clk);
      one_bit(3, 7, "R10", 0, 0);
      one_bit(0, 3, "R3", 0, 0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule